// File: doc/BRIEF.md
# Mesochronous receive synchronizer

This block carries a data word from a sending clock domain into a receiving clock domain. The two clocks share one nominal frequency, but their phase relationship is unknown and drifts slowly. No chain of delay flops is used. Every incoming word, and a toggle line that the sender inverts with each new word, is sampled twice: once on the rising edge of the receive clock and once on the falling edge. For any phase, at least one of the two samples lies away from the sender's transition window. A phase observer watches the toggle samples to decide which capture is the clean one. A selection state machine then forwards that capture into the receive domain.

The falling-edge capture is re-registered on the next rising edge, so both candidates are aligned to the rising edge before the selection mux. The observer needs a run of identical verdicts before it is trusted, which gives hysteresis against jitter. The state machine moves the mux from one candidate to the other only in a cycle where both candidates carry the same word, so a switch never inserts a stale or foreign value.

The state machine has five states:
- EVAL: after reset, output not yet valid.
- RISE: forwarding the rising capture.
- FALL: forwarding the falling capture.
- GO_FALL: rising capture still selected, waiting to move to the falling capture.
- GO_RISE: falling capture still selected, waiting to move to the rising capture.

Its transitions are:
- eval_done_rise: EVAL to RISE.
- eval_done_fall: EVAL to FALL.
- swap_to_fall: RISE or GO_FALL to FALL, when the candidates are equal.
- defer_fall: RISE to GO_FALL, when the candidates differ.
- swap_to_rise: FALL or GO_RISE to RISE, when the candidates are equal.
- defer_rise: FALL to GO_RISE, when the candidates differ.
- cancel_fall: GO_FALL back to RISE.
- cancel_rise: GO_RISE back to FALL.

Top module: `meso_rx_sync`

## Requirements
- R1: While `rst_n` is low, `rx_data` is all zeros, `rx_valid` is 0 and `rx_sel_fall` is 0, so the rising capture is selected.
- R2: `rx_valid` stays 0 after reset until the observer has produced HYST_LEN (default 8) consecutive identical verdicts. Once it rises, it stays 1 until the next reset.
- R3: A toggle transition that lands in the half period just after a rising receive edge makes the rising capture unsafe, and the settled selection becomes `rx_sel_fall`=1. A transition in the half period just after a falling edge makes the falling capture unsafe, and the settled selection becomes `rx_sel_fall`=0.
- R4: The selection changes only after HYST_LEN consecutive identical verdicts. A receive cycle in which no toggle transition is seen neither advances nor breaks the run. Alternating runs shorter than HYST_LEN leave `rx_sel_fall` unchanged.
- R5: The mux moves to the other candidate only in a cycle where both candidates hold the same word. Across a switch, `rx_data` shows no value out of order and no value that the sender did not launch.
- R6: At a fixed phase, a word launched during the receive period that begins at rising edge k appears on `rx_data` just after rising edge k+2. Latency is therefore constant.
- R7: The sender presents a new word together with an inversion of `tx_toggle`. At any fixed phase away from the receive edges, every word launched after valid is reached comes out once, unchanged and in order, with none lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rx_clk | input | 1 | Receive clock; both edges are used for capture |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_data | input | DATA_W | Word launched from the sending domain |
| tx_toggle | input | 1 | Inverted by the sender with every new word |
| rx_data | output | DATA_W | Forwarded word, registered on the rising edge |
| rx_valid | output | 1 | High once the first phase evaluation has completed |
| rx_sel_fall | output | 1 | 1 = falling capture forwarded, 0 = rising capture forwarded |

## Verification
A verdict counter that is off, or a stuck state, shows up as `rx_valid` rising after too few toggle transitions. It also shows up as `rx_sel_fall` reacting to jitter bursts shorter than the hysteresis run, within a dozen cycles of the burst. A wrong phase rule or a missing re-register leaves `rx_sel_fall` on the wrong side for a given sender offset. It also moves the launch-to-output latency by a whole receive period, and that is visible on the very first word after valid. A switch made while the candidates differ drops or repeats a word at the instant of the switch, so the in-order scoreboard flags it on the next output change.

// File: rtl/meso_sync_pkg.sv
`timescale 1ns/1ps
package meso_sync_pkg;

    // selection state machine
    typedef enum logic [2:0] {
        ST_EVAL,     // post-reset evaluation, output not valid
        ST_RISE,     // rising-edge capture forwarded
        ST_FALL,     // falling-edge capture forwarded
        ST_GO_FALL,  // rising still forwarded, waiting for equal candidates
        ST_GO_RISE   // falling still forwarded, waiting for equal candidates
    } sel_state_e;

    // per-cycle observer verdict: which capture is the safe one
    typedef enum logic [1:0] {
        VD_NONE,
        VD_RISE,
        VD_FALL
    } verdict_e;

endpackage

// File: rtl/meso_dual_capture.sv
`timescale 1ns/1ps
module meso_dual_capture #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_toggle,
    output logic [DATA_W-1:0] cand_rise,
    output logic [DATA_W-1:0] cand_fall,
    output logic              tgl_rise,
    output logic              tgl_fall
);

    localparam int LANE_W = DATA_W + 1;

    logic [LANE_W-1:0] lane_in;
    logic [LANE_W-1:0] rise_q;
    logic [LANE_W-1:0] fall_q;
    logic [DATA_W-1:0] fall_rt_q;

    assign lane_in = {tx_toggle, tx_data};

    // rising-edge sample of word and toggle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_q <= '0;
        end else begin
            rise_q <= lane_in;
        end
    end

    // falling-edge sample, half a period away from the rising one
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fall_q <= '0;
        end else begin
            fall_q <= lane_in;
        end
    end

    // bring the falling sample onto the rising edge before the mux
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fall_rt_q <= '0;
        end else begin
            fall_rt_q <= fall_q[DATA_W-1:0];
        end
    end

    assign cand_rise = rise_q[DATA_W-1:0];
    assign cand_fall = fall_rt_q;
    assign tgl_rise  = rise_q[DATA_W];
    assign tgl_fall  = fall_q[DATA_W];

endmodule

// File: rtl/meso_phase_observer.sv
`timescale 1ns/1ps
module meso_phase_observer
    import meso_sync_pkg::*;
#(
    parameter int HYST_LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tgl_rise,
    input  logic tgl_fall,
    output logic vd_stable,
    output logic vd_fall
);

    localparam int CNT_W = $clog2(HYST_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(HYST_LEN);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic             rise_old_q;
    logic             fall_old_q;
    verdict_e         vd_now;
    verdict_e         vd_last_q;
    logic [CNT_W-1:0] run_q;

    // At a rising edge the three oldest samples are, in time order:
    // rise_old_q (two periods back), fall_old_q (1.5 back), tgl_rise (1 back).
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_old_q <= 1'b0;
            fall_old_q <= 1'b0;
        end else begin
            rise_old_q <= tgl_rise;
            fall_old_q <= tgl_fall;
        end
    end

    // Transition just after a rising edge: rising capture is unsafe.
    // Transition just after a falling edge: falling capture is unsafe.
    always_comb begin
        vd_now = VD_NONE;
        if ((rise_old_q != fall_old_q) && (fall_old_q == tgl_rise)) begin
            vd_now = VD_FALL;
        end else if ((rise_old_q == fall_old_q) && (fall_old_q != tgl_rise)) begin
            vd_now = VD_RISE;
        end
    end

    // run-length of identical verdicts, saturating at HYST_LEN
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vd_last_q <= VD_NONE;
            run_q     <= '0;
        end else if (vd_now != VD_NONE) begin
            if (vd_now == vd_last_q) begin
                if (run_q != CNT_MAX) begin
                    run_q <= run_q + CNT_ONE;
                end
            end else begin
                vd_last_q <= vd_now;
                run_q     <= CNT_ONE;
            end
        end
    end

    assign vd_stable = (run_q == CNT_MAX);
    assign vd_fall   = (vd_last_q == VD_FALL);

    // R4: the run grows one verdict at a time, never jumps
    p_run_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q > $past(run_q)) |-> (run_q == $past(run_q) + CNT_ONE));

    // R4: a change of the remembered verdict always restarts the run
    p_run_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (vd_last_q != $past(vd_last_q)) |-> (run_q == CNT_ONE));

endmodule

// File: rtl/meso_sel_fsm.sv
`timescale 1ns/1ps
module meso_sel_fsm
    import meso_sync_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic vd_stable,
    input  logic vd_fall,
    input  logic cand_eq,
    output logic sel_fall,
    output logic out_valid
);

    sel_state_e state_q;
    sel_state_e state_nx;
    logic       want_fall;
    logic       want_rise;

    assign want_fall = vd_stable && vd_fall;
    assign want_rise = vd_stable && !vd_fall;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EVAL;
        end else begin
            state_q <= state_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_EVAL: begin
                if (want_fall)      state_nx = ST_FALL;     // eval_done_fall
                else if (want_rise) state_nx = ST_RISE;     // eval_done_rise
            end
            ST_RISE: begin
                if (want_fall) begin
                    if (cand_eq)    state_nx = ST_FALL;     // swap_to_fall
                    else            state_nx = ST_GO_FALL;  // defer_fall
                end
            end
            ST_GO_FALL: begin
                if (want_fall && cand_eq) state_nx = ST_FALL;  // swap_to_fall
                else if (want_rise)       state_nx = ST_RISE;  // cancel_fall
            end
            ST_FALL: begin
                if (want_rise) begin
                    if (cand_eq)    state_nx = ST_RISE;     // swap_to_rise
                    else            state_nx = ST_GO_RISE;  // defer_rise
                end
            end
            ST_GO_RISE: begin
                if (want_rise && cand_eq) state_nx = ST_RISE;  // swap_to_rise
                else if (want_fall)       state_nx = ST_FALL;  // cancel_rise
            end
            default: state_nx = ST_EVAL;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        sel_fall  = 1'b0;
        out_valid = 1'b1;
        unique case (state_q)
            ST_EVAL:    out_valid = 1'b0;
            ST_RISE:    sel_fall  = 1'b0;
            ST_GO_FALL: sel_fall  = 1'b0;
            ST_FALL:    sel_fall  = 1'b1;
            ST_GO_RISE: sel_fall  = 1'b1;
            default: begin
                sel_fall  = 1'b0;
                out_valid = 1'b0;
            end
        endcase
    end

    // R5: once valid, a change of selection happens only from equal candidates
    p_swap_equal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(out_valid) && (sel_fall != $past(sel_fall))) |-> $past(cand_eq));

    // R4: a change of selection needs a completed verdict run
    p_swap_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_fall != $past(sel_fall)) |-> $past(vd_stable));

    // R2: valid rises only after a completed verdict run
    p_valid_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(vd_stable));

    // R2: valid never drops outside reset
    p_valid_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> out_valid);

endmodule

// File: rtl/meso_rx_sync.sv
`timescale 1ns/1ps
module meso_rx_sync #(
    parameter int DATA_W   = 16,
    parameter int HYST_LEN = 8
) (
    input  logic              rx_clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_toggle,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_sel_fall
);

    logic [DATA_W-1:0] cand_rise;
    logic [DATA_W-1:0] cand_fall;
    logic              tgl_rise;
    logic              tgl_fall;
    logic              vd_stable;
    logic              vd_fall;
    logic              cand_eq;
    logic              sel_fall;
    logic              out_valid;

    meso_dual_capture #(
        .DATA_W (DATA_W)
    ) i_capture (
        .clk       (rx_clk),
        .rst_n     (rst_n),
        .tx_data   (tx_data),
        .tx_toggle (tx_toggle),
        .cand_rise (cand_rise),
        .cand_fall (cand_fall),
        .tgl_rise  (tgl_rise),
        .tgl_fall  (tgl_fall)
    );

    meso_phase_observer #(
        .HYST_LEN (HYST_LEN)
    ) i_observer (
        .clk       (rx_clk),
        .rst_n     (rst_n),
        .tgl_rise  (tgl_rise),
        .tgl_fall  (tgl_fall),
        .vd_stable (vd_stable),
        .vd_fall   (vd_fall)
    );

    assign cand_eq = (cand_rise == cand_fall);

    meso_sel_fsm i_fsm (
        .clk       (rx_clk),
        .rst_n     (rst_n),
        .vd_stable (vd_stable),
        .vd_fall   (vd_fall),
        .cand_eq   (cand_eq),
        .sel_fall  (sel_fall),
        .out_valid (out_valid)
    );

    // registered output of the selected, edge-aligned candidate
    always_ff @(posedge rx_clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data <= '0;
        end else begin
            rx_data <= sel_fall ? cand_fall : cand_rise;
        end
    end

    assign rx_valid    = out_valid;
    assign rx_sel_fall = sel_fall;

    // R1/R5: the forwarded word only changes to what one candidate held
    p_out_source_r5: assert property (@(posedge rx_clk) disable iff (!rst_n)
        (rx_data != $past(rx_data)) |->
            ((rx_data == $past(cand_rise)) || (rx_data == $past(cand_fall))));

endmodule

// File: tb/test_meso_rx_sync.sv
`timescale 1ns/1ps
module test_meso_rx_sync;

    localparam int    DW  = 16;
    localparam realtime TP = 5.0;

    typedef struct {
        logic [DW-1:0] w;
        realtime       t;
    } sb_item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] tx_data = '0;
    logic          tx_toggle = 1'b0;
    logic [DW-1:0] rx_data;
    logic          rx_valid;
    logic          rx_sel_fall;

    int            n_checks = 0;
    int            n_errors = 0;
    bit            finished = 0;

    sb_item_t      sb_q[$];
    logic [DW-1:0] next_word = 16'h1000;
    int            word_cnt = 0;
    int            hold_every = 0;
    bit            mon_synced = 0;
    bit            lat_on = 0;
    realtime       lat_exp = 0.0;
    realtime       last_lat = 0.0;
    logic [DW-1:0] last_out = '0;
    int            sel_changes = 0;
    logic          sel_prev = 1'b0;

    meso_rx_sync #(.DATA_W(DW), .HYST_LEN(8)) i_meso_rx_sync (
        .rx_clk      (clk),
        .rst_n       (rst_n),
        .tx_data     (tx_data),
        .tx_toggle   (tx_toggle),
        .rx_data     (rx_data),
        .rx_valid    (rx_valid),
        .rx_sel_fall (rx_sel_fall)
    );

    always #2.5 clk = ~clk;   // 200 MHz

    task automatic chk(input bit ok, input string msg);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s", msg);
        end
    endtask

    // driver: one word per receive period, launched off after the rising edge
    task automatic send(input int n, input realtime off);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #(off);
            tx_data   = next_word;
            tx_toggle = ~tx_toggle;
            sb_q.push_back('{w: next_word, t: $realtime});
            next_word = next_word + 1'b1;
            word_cnt++;
            if (hold_every != 0 && (word_cnt % hold_every) == 0) begin
                @(posedge clk);   // one period without a new word
            end
        end
    endtask

    task automatic restart();
        rst_n = 1'b0;
        tx_toggle = 1'b0;
        tx_data = '0;
        sb_q.delete();
        mon_synced = 0;
        hold_every = 0;
        repeat (3) @(posedge clk);
        #1.25;
        chk(rx_data == '0, $sformatf("R1 reset data act=%h exp=0", rx_data));
        chk(rx_valid == 1'b0, $sformatf("R1 reset valid act=%b exp=0", rx_valid));
        chk(rx_sel_fall == 1'b0, $sformatf("R1 reset sel act=%b exp=0", rx_sel_fall));
        @(posedge clk);
        #1.0;
        rst_n = 1'b1;
    endtask

    // monitor: pops the scoreboard on every change of the forwarded word
    initial begin
        forever begin
            @(posedge clk);
            #1.25;
            if (rst_n && rx_valid) begin
                if (rx_sel_fall != sel_prev) sel_changes++;
                sel_prev = rx_sel_fall;
                if (!mon_synced) begin
                    while (sb_q.size() > 0 && sb_q[0].w != rx_data) void'(sb_q.pop_front());
                    chk(sb_q.size() > 0, $sformatf("R7 first valid word act=%h exp=launched word", rx_data));
                    if (sb_q.size() > 0) void'(sb_q.pop_front());
                    mon_synced = 1;
                    last_out = rx_data;
                end else if (rx_data != last_out) begin
                    if (sb_q.size() == 0) begin
                        chk(0, $sformatf("R5 unexpected word act=%h exp=none", rx_data));
                    end else begin
                        sb_item_t e;
                        realtime  d;
                        e = sb_q.pop_front();
                        chk(e.w == rx_data, $sformatf("R7 order act=%h exp=%h", rx_data, e.w));
                        last_lat = $realtime - e.t;
                        if (lat_on) begin
                            d = (last_lat > lat_exp) ? last_lat - lat_exp : lat_exp - last_lat;
                            chk(d < 0.01, $sformatf("R6 latency act=%0.3f exp=%0.3f", last_lat, lat_exp));
                        end
                    end
                    last_out = rx_data;
                end
            end else begin
                sel_prev = 1'b0;
            end
        end
    end

    task automatic fixed_run(input realtime off);
        bit exp_fall;
        exp_fall = (off < TP / 2.0);
        restart();
        lat_on  = 1;
        lat_exp = 2.0 * TP + 1.25 - off;
        fork
            send(40, off);
            begin
                repeat (6) @(posedge clk);
                #1.25;
                chk(rx_valid == 1'b0, $sformatf("R2 valid early act=%b exp=0", rx_valid));
            end
        join
        repeat (6) @(posedge clk);
        #1.25;
        chk(rx_valid == 1'b1, $sformatf("R2 valid late act=%b exp=1", rx_valid));
        chk(rx_sel_fall == exp_fall,
            $sformatf("R3 select at offset %0.2f act=%b exp=%b", off, rx_sel_fall, exp_fall));
        chk(sb_q.size() == 0, $sformatf("R7 words left act=%0d exp=0", sb_q.size()));
        lat_on = 0;
    endtask

    initial begin
        // R1 R2 R3 R6 R7: sweep of fixed phases, avoiding both receive edges
        for (int k = 1; k < 10; k++) begin
            if (k != 5) fixed_run(0.5 * k);
        end

        // R5 R4: slow drift across the falling edge and back, with idle periods
        restart();
        hold_every = 6;
        send(24, 1.05);
        chk(rx_sel_fall == 1'b1, $sformatf("R3 drift start act=%b exp=1", rx_sel_fall));
        for (int s = 1; s <= 15; s++) send(4, 1.05 + 0.2 * s);
        send(30, 4.05);
        repeat (4) @(posedge clk);
        #1.25;
        chk(rx_sel_fall == 1'b0, $sformatf("R5 drift up act=%b exp=0", rx_sel_fall));
        chk((last_lat > 7.19) && (last_lat < 7.21),
            $sformatf("R6 latency after drift up act=%0.3f exp=7.200", last_lat));
        for (int s = 14; s >= 0; s--) send(4, 1.05 + 0.2 * s);
        send(30, 1.05);
        repeat (6) @(posedge clk);
        #1.25;
        chk(rx_sel_fall == 1'b1, $sformatf("R5 drift down act=%b exp=1", rx_sel_fall));
        chk(sel_changes >= 2, $sformatf("R5 switches act=%0d exp>=2", sel_changes));
        chk(sb_q.size() == 0, $sformatf("R5 words left act=%0d exp=0", sb_q.size()));
        chk((last_lat > 10.19) && (last_lat < 10.21),
            $sformatf("R6 latency after drift down act=%0.3f exp=10.200", last_lat));

        // R4: jitter bursts shorter than the hysteresis run
        restart();
        send(24, 3.55);
        repeat (3) @(posedge clk);
        #1.25;
        chk(rx_sel_fall == 1'b0, $sformatf("R3 jitter start act=%b exp=0", rx_sel_fall));
        sel_changes = 0;
        for (int j = 0; j < 6; j++) begin
            send(5, 2.35);
            send(5, 2.65);
        end
        repeat (3) @(posedge clk);
        #1.25;
        chk(sel_changes == 0, $sformatf("R4 jitter switches act=%0d exp=0", sel_changes));
        chk(rx_sel_fall == 1'b0, $sformatf("R4 jitter select act=%b exp=0", rx_sel_fall));
        send(20, 2.35);
        repeat (4) @(posedge clk);
        #1.25;
        chk(rx_sel_fall == 1'b1, $sformatf("R4 settled select act=%b exp=1", rx_sel_fall));
        chk(sb_q.size() == 0, $sformatf("R7 jitter words left act=%0d exp=0", sb_q.size()));

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(TP * 100000.0);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired act=running exp=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule